// File: doc/BRIEF.md
# Two-Wire Serial Slave Register Access Engine

This block is a slave on a two-wire serial bus (an open-drain clock line and an open-drain data line). It gives the bus master byte access to a 10-bit register address space through a synchronous register port. The block samples both lines in its own system clock domain, recognises bus START and STOP conditions, and answers only to its own 7-bit device address. That address, together with a protocol-select strap, is captured when reset is released.

A normal transfer has four parts. The master sends the device address byte, then an instruction byte, then a low address byte, and then any number of data bytes. The instruction byte carries a 4-bit opcode in its upper nibble and address bits 9:8 in its two lowest bits. The opcode selects between reading and writing, and between advancing the address pointer and holding it. In the advancing modes the pointer steps after every data byte and then steps once more when the transfer ends.

If the direction bit of the device address byte is set, the block skips the instruction and address bytes. It goes straight to returning data from the current pointer and keeps the increment setting of the last instruction.

Top module: `twi_reg_slave`

## Requirements
- R1: While reset is low the block drives no line and issues no register strobe. The device address and the protocol-select strap are taken from the strap pins at reset release, and later strap changes have no effect. A protocol-select value of 1 keeps the block silent on the bus.
- R2: A falling data line while the clock is high is a START and a rising data line while the clock is high is a STOP. A START arriving in the middle of a transfer ends that transfer and opens a new one.
- R3: The device address byte carries the address in bits 7:1 and the direction in bit 0, most significant bit first. On a match the block pulls the data line low during the ninth clock. On a mismatch it leaves the line released for the whole transfer.
- R4: After a direction-0 address byte, the next byte is the instruction: opcode in bits 7:4, bits 3:2 ignored, address bits 9:8 in bits 1:0. The byte after it gives address bits 7:0. Both bytes are acknowledged.
- R5: Opcode 0001 writes. Each received data byte is acknowledged and produces one single-cycle write strobe at the pointer, and the pointer then steps by one, wrapping from 1023 to 0.
- R6: Opcode 0010 writes every data byte to the same address.
- R7: Opcode 1001 returns register data, most significant bit first, starting at the loaded address and stepping by one after each byte.
- R8: Opcode 1010 returns the register at the same address for every byte.
- R9: In the stepping modes, a transfer that reached its data phase moves the pointer one further place when it ends, whether it ends by STOP or by a new START. In the holding modes it does not move.
- R10: A device address byte with direction bit 1 starts returning data at once from the current pointer, using the stepping setting of the last accepted instruction.
- R11: Any other opcode still has its instruction and address bytes acknowledged. Its data bytes are not acknowledged and cause no register access.
- R12: When the master does not acknowledge a returned byte, the block releases the data line and keeps it released until the next START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8 times the serial clock rate |
| rst_n | input | 1 | Active-low reset; straps are captured at its release |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_oe | output | 1 | When 1, the pad pulls the data line low |
| strap_dev_addr | input | 7 | Device address strap |
| strap_proto_sel | input | 1 | Protocol select strap; 0 enables this two-wire slave |
| reg_wr_en | output | 1 | Single-cycle register write strobe |
| reg_rd_en | output | 1 | Single-cycle register read strobe |
| reg_addr | output | 10 | Register address (current pointer) |
| reg_wdata | output | 8 | Write data, valid with reg_wr_en |
| reg_rdata | input | 8 | Read data, valid the cycle after reg_rd_en |

## Verification
The bench builds the block with its default two-stage synchronisers and a serial clock of 20 system cycles, so the load-to-first-bit path on reads is exercised with little spare margin in the low phase. Because the address is loaded directly, the bench can place the pointer at 1022 and reach the 1023-to-0 wrap within three bytes. Each termination step can then be seen as the start address of a following direction-1 read. The device address strap is changed both at runtime and across a reset, and the protocol-select strap is set to 1 for one run.

// File: rtl/twi_reg_pkg.sv
package twi_reg_pkg;

  localparam int ADDR_W = 10;
  localparam int DATA_W = 8;
  localparam int DEV_W  = 7;
  localparam int HI_W   = ADDR_W - DATA_W;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_INSTR,
    ST_ADDR,
    ST_WDATA,
    ST_RDATA,
    ST_SKIP,
    ST_DONE
  } twi_state_e;

  localparam logic [3:0] OP_WR_STEP = 4'b0001;
  localparam logic [3:0] OP_WR_HOLD = 4'b0010;
  localparam logic [3:0] OP_RD_STEP = 4'b1001;
  localparam logic [3:0] OP_RD_HOLD = 4'b1010;

  function automatic logic op_accesses(input logic [3:0] op);
    return (op == OP_WR_STEP) || (op == OP_WR_HOLD) ||
           (op == OP_RD_STEP) || (op == OP_RD_HOLD);
  endfunction

  function automatic logic op_reads(input logic [3:0] op);
    return (op == OP_RD_STEP) || (op == OP_RD_HOLD);
  endfunction

  function automatic logic op_steps(input logic [3:0] op);
    return (op == OP_WR_STEP) || (op == OP_RD_STEP);
  endfunction

  function automatic logic [ADDR_W-1:0] ptr_step(input logic [ADDR_W-1:0] p,
                                                 input logic inc);
    return p + {{(ADDR_W-1){1'b0}}, inc};
  endfunction

endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);

  logic [STAGES-1:0] scl_pipe;
  logic [STAGES-1:0] sda_pipe;
  logic              scl_q;
  logic              sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_q    <= scl_pipe[STAGES-1];
      sda_q    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_s     = scl_pipe[STAGES-1];
  assign sda_s     = sda_pipe[STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  // data edges only count while the clock has been high for two samples
  assign start_evt = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_evt  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/twi_strap_latch.sv
module twi_strap_latch
  import twi_reg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DEV_W-1:0] strap_dev_addr,
  input  logic             strap_proto_sel,
  output logic [DEV_W-1:0] dev_addr_q,
  output logic             proto_q
);

  // follows the pins while reset is held, freezes at release
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dev_addr_q <= strap_dev_addr;
      proto_q    <= strap_proto_sel;
    end
  end

endmodule

// File: rtl/twi_ctrl.sv
module twi_ctrl
  import twi_reg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              sda_s,
  input  logic              start_evt,
  input  logic              stop_evt,
  input  logic [DEV_W-1:0]  dev_addr,
  input  logic              proto_sel,
  input  logic [DATA_W-1:0] reg_rdata,
  output logic              sda_oe,
  output logic              reg_wr_en,
  output logic              reg_rd_en,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [DATA_W-1:0] reg_wdata,
  output twi_state_e        state_o
);

  localparam logic [3:0] BITS     = 4'(DATA_W);
  localparam logic [3:0] ACK_SLOT = 4'(DATA_W + 1);

  twi_state_e        state_q;
  logic [3:0]        bit_cnt_q;
  logic [DATA_W-1:0] shreg_q;
  logic [DATA_W-1:0] wdata_q;
  logic [ADDR_W-1:0] ptr_q;
  logic [3:0]        op_q;
  logic [HI_W-1:0]   hi_q;
  logic              step_q;
  logic              adv_pend_q;
  logic              ack_q;
  logic              rw_q;
  logic              mack_q;
  logic              sda_oe_q;
  logic              wr_en_q;
  logic              rd_en_q;
  logic              load_pend_q;

  logic byte_done;
  logic slot_done;
  logic tx_shift;
  logic bus_event;

  assign bus_event = start_evt | stop_evt;
  assign byte_done = scl_fall && (bit_cnt_q == BITS);
  assign slot_done = scl_fall && (bit_cnt_q == ACK_SLOT);
  assign tx_shift  = scl_fall && (state_q == ST_RDATA) &&
                     (bit_cnt_q != 4'd0) && (bit_cnt_q < BITS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      bit_cnt_q   <= '0;
      shreg_q     <= '0;
      wdata_q     <= '0;
      ptr_q       <= '0;
      op_q        <= '0;
      hi_q        <= '0;
      step_q      <= 1'b0;
      adv_pend_q  <= 1'b0;
      ack_q       <= 1'b0;
      rw_q        <= 1'b0;
      mack_q      <= 1'b0;
      sda_oe_q    <= 1'b0;
      wr_en_q     <= 1'b0;
      rd_en_q     <= 1'b0;
      load_pend_q <= 1'b0;
    end else begin
      wr_en_q <= 1'b0;
      rd_en_q <= 1'b0;

      // read data arrives the cycle after the strobe
      if (rd_en_q) load_pend_q <= 1'b1;
      if (load_pend_q) begin
        shreg_q     <= reg_rdata;
        sda_oe_q    <= ~reg_rdata[DATA_W-1];
        load_pend_q <= 1'b0;
      end

      if (bus_event) begin
        ptr_q       <= ptr_step(ptr_q, adv_pend_q);
        adv_pend_q  <= 1'b0;
        sda_oe_q    <= 1'b0;
        bit_cnt_q   <= '0;
        load_pend_q <= 1'b0;
        state_q     <= (start_evt && !proto_sel) ? ST_DEV : ST_IDLE;
      end else if (state_q != ST_IDLE) begin
        if (scl_rise) begin
          if (bit_cnt_q < BITS) begin
            if (state_q != ST_RDATA) shreg_q <= {shreg_q[DATA_W-2:0], sda_s};
            bit_cnt_q <= bit_cnt_q + 4'd1;
          end else if (bit_cnt_q == BITS) begin
            mack_q    <= ~sda_s;
            bit_cnt_q <= ACK_SLOT;
          end
        end

        if (tx_shift) begin
          shreg_q  <= {shreg_q[DATA_W-2:0], 1'b0};
          sda_oe_q <= ~shreg_q[DATA_W-2];
        end

        if (byte_done) begin
          unique case (state_q)
            ST_DEV: begin
              ack_q <= (shreg_q[DATA_W-1:1] == dev_addr);
              rw_q  <= shreg_q[0];
              if (shreg_q[DATA_W-1:1] == dev_addr) sda_oe_q <= 1'b1;
            end
            ST_INSTR: begin
              sda_oe_q <= 1'b1;
              op_q     <= shreg_q[DATA_W-1:DATA_W-4];
              hi_q     <= shreg_q[HI_W-1:0];
            end
            ST_ADDR:  sda_oe_q <= 1'b1;
            ST_WDATA: begin
              sda_oe_q <= 1'b1;
              wr_en_q  <= 1'b1;
              wdata_q  <= shreg_q;
            end
            ST_RDATA: sda_oe_q <= 1'b0;
            default: ;
          endcase
        end

        if (slot_done) begin
          bit_cnt_q <= '0;
          unique case (state_q)
            ST_DEV: begin
              sda_oe_q <= 1'b0;
              if (!ack_q) begin
                state_q <= ST_SKIP;
              end else if (rw_q) begin
                state_q    <= ST_RDATA;
                rd_en_q    <= 1'b1;
                adv_pend_q <= step_q;
              end else begin
                state_q <= ST_INSTR;
              end
            end
            ST_INSTR: begin
              sda_oe_q <= 1'b0;
              state_q  <= ST_ADDR;
            end
            ST_ADDR: begin
              sda_oe_q <= 1'b0;
              if (op_accesses(op_q)) begin
                ptr_q      <= {hi_q, shreg_q};
                step_q     <= op_steps(op_q);
                adv_pend_q <= op_steps(op_q);
                if (op_reads(op_q)) begin
                  state_q <= ST_RDATA;
                  rd_en_q <= 1'b1;
                end else begin
                  state_q <= ST_WDATA;
                end
              end else begin
                state_q <= ST_SKIP;
              end
            end
            ST_WDATA: begin
              sda_oe_q <= 1'b0;
              ptr_q    <= ptr_step(ptr_q, step_q);
            end
            ST_RDATA: begin
              ptr_q <= ptr_step(ptr_q, step_q);
              if (mack_q) rd_en_q <= 1'b1;
              else        state_q <= ST_DONE;
            end
            default: ;
          endcase
        end
      end
    end
  end

  assign sda_oe    = sda_oe_q;
  assign reg_wr_en = wr_en_q;
  assign reg_rd_en = rd_en_q;
  assign reg_addr  = ptr_q;
  assign reg_wdata = wdata_q;
  assign state_o   = state_q;

endmodule

// File: rtl/twi_reg_slave.sv
module twi_reg_slave
  import twi_reg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic [DEV_W-1:0]  strap_dev_addr,
  input  logic              strap_proto_sel,
  output logic              reg_wr_en,
  output logic              reg_rd_en,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [DATA_W-1:0] reg_wdata,
  input  logic [DATA_W-1:0] reg_rdata
);

  logic             scl_s;
  logic             sda_s;
  logic             scl_rise;
  logic             scl_fall;
  logic             start_evt;
  logic             stop_evt;
  logic [DEV_W-1:0] dev_addr_q;
  logic             proto_q;
  twi_state_e       state;
  logic             in_skip;
  logic             in_done;

  twi_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_evt (start_evt),
    .stop_evt  (stop_evt)
  );

  twi_strap_latch u_strap (
    .clk             (clk),
    .rst_n           (rst_n),
    .strap_dev_addr  (strap_dev_addr),
    .strap_proto_sel (strap_proto_sel),
    .dev_addr_q      (dev_addr_q),
    .proto_q         (proto_q)
  );

  twi_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .sda_s     (sda_s),
    .start_evt (start_evt),
    .stop_evt  (stop_evt),
    .dev_addr  (dev_addr_q),
    .proto_sel (proto_q),
    .reg_rdata (reg_rdata),
    .sda_oe    (sda_oe),
    .reg_wr_en (reg_wr_en),
    .reg_rd_en (reg_rd_en),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .state_o   (state)
  );

  assign in_skip = (state == ST_SKIP);
  assign in_done = (state == ST_DONE);

endmodule

// File: rtl/twi_reg_slave_chk.sv
module twi_reg_slave_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_s,
  input logic start_evt,
  input logic sda_oe,
  input logic reg_wr_en,
  input logic reg_rd_en,
  input logic proto_q,
  input logic in_skip,
  input logic in_done
);

  a_r1_strap_silent: assert property (@(posedge clk) disable iff (!rst_n)
    proto_q |-> !sda_oe);

  a_r2_release_on_start: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> !sda_oe);

  a_r2_hold_while_clock_high: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_s && $past(scl_s)) |-> $stable(sda_oe));

  a_r5_write_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en |=> !reg_wr_en);

  a_r7_read_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd_en |=> !reg_rd_en);

  a_r5_no_mixed_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr_en && reg_rd_en));

  a_r11_skip_no_access: assert property (@(posedge clk) disable iff (!rst_n)
    in_skip |-> !(reg_wr_en || reg_rd_en));

  a_r12_silent_after_nack: assert property (@(posedge clk) disable iff (!rst_n)
    in_done |-> !sda_oe);

endmodule

bind twi_reg_slave twi_reg_slave_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .scl_s     (scl_s),
  .start_evt (start_evt),
  .sda_oe    (sda_oe),
  .reg_wr_en (reg_wr_en),
  .reg_rd_en (reg_rd_en),
  .proto_q   (proto_q),
  .in_skip   (in_skip),
  .in_done   (in_done)
);

// File: tb/twi_reg_slave_bench.sv
`timescale 1ns/1ps
module twi_reg_slave_bench;

  localparam int HALF = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       m_scl = 1'b1;
  logic       m_sda_low = 1'b0;
  logic       sda_line;
  logic       sda_oe;
  logic [6:0] strap_dev = 7'h52;
  logic       strap_proto = 1'b0;
  logic       reg_wr_en;
  logic       reg_rd_en;
  logic [9:0] reg_addr;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;
  logic [7:0] mem [0:1023];

  int total = 0;
  int bad = 0;
  bit finished = 0;

  typedef struct packed { logic [9:0] a; logic [7:0] d; } wr_item_t;
  wr_item_t exp_q[$];

  always #10 clk = ~clk;

  assign sda_line = ~(m_sda_low | sda_oe);

  twi_reg_slave u_twi_reg_slave (
    .clk             (clk),
    .rst_n           (rst_n),
    .scl_i           (m_scl),
    .sda_i           (sda_line),
    .sda_oe          (sda_oe),
    .strap_dev_addr  (strap_dev),
    .strap_proto_sel (strap_proto),
    .reg_wr_en       (reg_wr_en),
    .reg_rd_en       (reg_rd_en),
    .reg_addr        (reg_addr),
    .reg_wdata       (reg_wdata),
    .reg_rdata       (reg_rdata)
  );

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 37 + 11) % 256);
  endfunction

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = pat(i);
  end

  // register file model
  always @(posedge clk) begin
    if (reg_wr_en) mem[reg_addr] <= reg_wdata;
    if (reg_rd_en) reg_rdata <= mem[reg_addr];
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // scoreboard monitor for write strobes
  always @(negedge clk) begin
    if (rst_n && reg_wr_en) begin
      if (exp_q.size() == 0) begin
        total++;
        bad++;
        $display("FAIL R11 unexpected write actual=%0h/%0h expected=none", reg_addr, reg_wdata);
      end else begin
        wr_item_t it;
        it = exp_q.pop_front();
        check("R5 R6 write strobe", {14'd0, reg_addr, reg_wdata}, {14'd0, it.a, it.d});
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start;
    tick(HALF/2); m_sda_low = 1'b0;
    tick(HALF/2); m_scl = 1'b1;
    tick(HALF/2); m_sda_low = 1'b1;
    tick(HALF/2); m_scl = 1'b0;
  endtask

  task automatic bus_stop;
    tick(HALF/2); m_sda_low = 1'b1;
    tick(HALF/2); m_scl = 1'b1;
    tick(HALF/2); m_sda_low = 1'b0;
    tick(HALF);
  endtask

  task automatic send_chk(input logic [7:0] b, input logic exp_ack, input string req);
    logic ack;
    for (int i = 7; i >= 0; i--) begin
      tick(HALF/2); m_sda_low = ~b[i];
      tick(HALF/2); m_scl = 1'b1;
      tick(HALF);   m_scl = 1'b0;
    end
    tick(HALF/2); m_sda_low = 1'b0;
    tick(HALF/2); m_scl = 1'b1;
    tick(HALF/2); ack = ~sda_line;
    tick(HALF/2); m_scl = 1'b0;
    check(req, {31'd0, ack}, {31'd0, exp_ack});
  endtask

  task automatic recv_chk(input logic [7:0] exp, input logic mack, input string req);
    logic [7:0] b;
    m_sda_low = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      tick(HALF);   m_scl = 1'b1;
      tick(HALF/2); b[i] = sda_line;
      tick(HALF/2); m_scl = 1'b0;
    end
    tick(HALF/2); m_sda_low = mack;
    tick(HALF/2); m_scl = 1'b1;
    tick(HALF);   m_scl = 1'b0;
    tick(HALF/2); m_sda_low = 1'b0;
    check(req, {24'd0, b}, {24'd0, exp});
  endtask

  task automatic push_wr(input logic [9:0] a, input logic [7:0] d);
    wr_item_t it;
    it.a = a;
    it.d = d;
    exp_q.push_back(it);
  endtask

  task automatic do_reset(input logic [6:0] dev, input logic proto);
    rst_n = 1'b0;
    strap_dev = dev;
    strap_proto = proto;
    tick(5);
    rst_n = 1'b1;
    tick(5);
  endtask

  initial begin
    do_reset(7'h52, 1'b0);
    check("R1 reset sda released", {31'd0, sda_line}, 32'd1);
    check("R1 reset no write strobe", {31'd0, reg_wr_en}, 32'd0);
    check("R1 reset no read strobe", {31'd0, reg_rd_en}, 32'd0);

    // R3: foreign address is not acknowledged
    bus_start;
    send_chk({7'h21, 1'b0}, 1'b0, "R3 foreign address nack");
    send_chk(8'h13, 1'b0, "R3 silent after mismatch");
    bus_stop;

    // R5: stepping write across the 1023 to 0 wrap
    bus_start;
    send_chk({7'h52, 1'b0}, 1'b1, "R3 own address ack");
    send_chk(8'h13, 1'b1, "R4 instruction ack");
    send_chk(8'hFE, 1'b1, "R4 low address ack");
    push_wr(10'h3FE, 8'hA1); send_chk(8'hA1, 1'b1, "R5 data ack");
    push_wr(10'h3FF, 8'hB2); send_chk(8'hB2, 1'b1, "R5 data ack");
    push_wr(10'h000, 8'hC3); send_chk(8'hC3, 1'b1, "R5 data ack after wrap");
    bus_stop;
    // pointer 0x001 after bytes, 0x002 after STOP (R9), read via direction bit (R10)
    bus_start;
    send_chk({7'h52, 1'b1}, 1'b1, "R10 direction read ack");
    recv_chk(pat(2), 1'b1, "R9 R10 pointer after stepping write");
    recv_chk(pat(3), 1'b0, "R10 keeps stepping setting");
    bus_stop;

    // R6: held write
    bus_start;
    send_chk({7'h52, 1'b0}, 1'b1, "R3 own address ack");
    send_chk(8'h21, 1'b1, "R4 instruction ack");
    send_chk(8'h55, 1'b1, "R4 low address ack");
    push_wr(10'h155, 8'h5A); send_chk(8'h5A, 1'b1, "R6 data ack");
    push_wr(10'h155, 8'h6B); send_chk(8'h6B, 1'b1, "R6 data ack");
    bus_stop;
    bus_start;
    send_chk({7'h52, 1'b1}, 1'b1, "R10 direction read ack");
    recv_chk(8'h6B, 1'b1, "R6 R9 held pointer after write");
    recv_chk(8'h6B, 1'b0, "R10 keeps holding setting");
    bus_stop;

    // R7: stepping read, then R12 released after nack
    bus_start;
    send_chk({7'h52, 1'b0}, 1'b1, "R3 own address ack");
    send_chk(8'h9D, 1'b1, "R4 instruction ack with bits 3:2 set");
    send_chk(8'h20, 1'b1, "R4 low address ack");
    recv_chk(pat(10'h120), 1'b1, "R7 first byte");
    recv_chk(pat(10'h121), 1'b1, "R7 second byte");
    recv_chk(pat(10'h122), 1'b0, "R7 third byte");
    begin
      logic probe;
      tick(HALF); m_scl = 1'b1;
      tick(HALF/2); probe = sda_line;
      tick(HALF/2); m_scl = 1'b0;
      check("R12 line released after nack", {31'd0, probe}, 32'd1);
    end
    bus_stop;
    // R2 R9: transfer ended by a new START also steps the pointer
    bus_start;
    send_chk({7'h52, 1'b1}, 1'b1, "R10 direction read ack");
    recv_chk(pat(10'h124), 1'b0, "R9 stop step after stepping read");
    bus_start;
    send_chk({7'h52, 1'b1}, 1'b1, "R2 repeated start address ack");
    recv_chk(pat(10'h126), 1'b0, "R2 R9 repeated start step");
    bus_stop;

    // R8: held read
    bus_start;
    send_chk({7'h52, 1'b0}, 1'b1, "R3 own address ack");
    send_chk(8'hA2, 1'b1, "R4 instruction ack");
    send_chk(8'h33, 1'b1, "R4 low address ack");
    recv_chk(pat(10'h233), 1'b1, "R8 first byte");
    recv_chk(pat(10'h233), 1'b0, "R8 second byte same address");
    bus_stop;
    bus_start;
    send_chk({7'h52, 1'b1}, 1'b1, "R10 direction read ack");
    recv_chk(pat(10'h233), 1'b0, "R9 no step in hold mode");
    bus_stop;

    // R11: unused opcode
    bus_start;
    send_chk({7'h52, 1'b0}, 1'b1, "R3 own address ack");
    send_chk(8'h30, 1'b1, "R11 instruction ack");
    send_chk(8'h44, 1'b1, "R11 address ack");
    send_chk(8'h99, 1'b0, "R11 data not acknowledged");
    bus_stop;
    check("R11 no writes pending", exp_q.size(), 32'd0);

    // R5 R9: stepping write closed by repeated START
    bus_start;
    send_chk({7'h52, 1'b0}, 1'b1, "R3 own address ack");
    send_chk(8'h10, 1'b1, "R4 instruction ack");
    send_chk(8'h50, 1'b1, "R4 low address ack");
    push_wr(10'h050, 8'h77); send_chk(8'h77, 1'b1, "R5 data ack");
    bus_start;
    send_chk({7'h52, 1'b1}, 1'b1, "R2 repeated start address ack");
    recv_chk(pat(10'h052), 1'b0, "R2 R9 step after write ended by start");
    bus_stop;
    bus_start;
    send_chk({7'h52, 1'b0}, 1'b1, "R3 own address ack");
    send_chk(8'hA0, 1'b1, "R4 instruction ack");
    send_chk(8'h50, 1'b1, "R4 low address ack");
    recv_chk(8'h77, 1'b0, "R5 written value read back");
    bus_stop;

    // R1: runtime strap change ignored, reset captures new straps
    strap_dev = 7'h11;
    tick(20);
    bus_start;
    send_chk({7'h52, 1'b0}, 1'b1, "R1 strap change ignored");
    bus_stop;
    do_reset(7'h11, 1'b1);
    bus_start;
    send_chk({7'h11, 1'b0}, 1'b0, "R1 protocol strap silences block");
    bus_stop;
    do_reset(7'h11, 1'b0);
    bus_start;
    send_chk({7'h11, 1'b0}, 1'b1, "R1 new address captured at reset");
    bus_stop;

    check("R11 scoreboard empty at end", exp_q.size(), 32'd0);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule